// File: doc/BRIEF.md
# Shared Branch Direction Predictor with Per-Core Exception Tables

This block predicts conditional branch directions for a small cluster of cores. A single large table of 2-bit saturating counters is shared by every core and indexed by low branch address bits. Because all cores train the same counters, a branch whose behaviour differs from core to core can keep losing in the shared table. To handle that case, each core also owns a small, fully associative exception table. An entry is created only after the shared table has steered that core wrong. While the entry lives, it overrides the shared counter for that core alone.

Each core has a lookup port and an update port. On the lookup port a PC goes in and a taken/not-taken bit comes out combinationally. On the update port the core reports a resolved branch: its PC, the actual direction, and whether the prediction it used was wrong. The shared table has one write port. When several cores resolve in the same cycle, a fixed-priority choice picks one shared write and the other shared writes are discarded. Every core's private exception table is still updated.

An exception entry retires itself once it has become redundant. That happens when the shared table already predicts the branch correctly and the entry's own counter has saturated in that same direction.

Top module: `shared_branch_predictor`

## Requirements
- R1: The shared table holds 2**IDX_W 2-bit counters, indexed by PC bits [IDX_W+1:2]. Counter bit 1 is the prediction (1 = taken). An update made through one core is seen by the lookups of every core.
- R2: On every shared write the counter at the updated index moves one step toward the actual outcome and saturates at 3 (taken) and 0 (not taken). The mispredict flag does not affect this.
- R3: An update with up_mispred=1 that misses the core's exception table allocates an entry. The entry's tag is PC bits [TAG_W+1:2] and its counter is 2 (taken) or 1 (not taken). An update with up_mispred=0 never allocates. Other cores' tables are never touched.
- R4: A lookup hits when a valid entry's tag equals PC bits [TAG_W+1:2]. On a hit the entry's counter bit 1 is the prediction, and on a miss the shared counter's bit 1 is used. PCs that differ only in bits above TAG_W+1 alias to the same entry.
- R5: An update that hits the core's exception table trains that entry's counter with saturation, whatever up_mispred says, and allocates nothing.
- R6: A hitting entry is invalidated instead of trained when two conditions hold: the shared counter, read before this update, already predicted the actual outcome, and the trained counter would sit saturated in that direction.
- R7: Each core has EXC_DEPTH (default 8) entries. Allocation uses a round-robin pointer that starts at slot 0 after reset and advances once per allocation, overwriting the slot it points at. The (EXC_DEPTH+1)-th allocation replaces the first.
- R8: Among the cores with up_valid=1, the lowest-numbered one writes the shared table. The shared writes of the others are dropped without stall, but their exception tables still update.
- R9: After reset every exception entry is invalid and every shared counter is 1, so all lookups return not-taken and a single taken update flips the shared prediction.
- R10: Lookup is combinational from the stored state. Updates change state at the next rising clock edge, so a lookup in the same cycle as an update returns the old prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | NUM_CORES*PC_W | Lookup PC for each core, core c in bits [c*PC_W +: PC_W] |
| lk_taken | output | NUM_CORES | Predicted direction for each core (1 = taken) |
| up_valid | input | NUM_CORES | Resolved-branch update valid for each core |
| up_pc | input | NUM_CORES*PC_W | PC of the resolved branch for each core |
| up_taken | input | NUM_CORES | Actual direction of the resolved branch |
| up_mispred | input | NUM_CORES | The prediction the core used for this branch was wrong |

## Verification
A corrupted shared counter shows up as a flipped prediction on every core that looks up that index, starting the cycle after the faulty edge. A wrong exception entry shows up only on its own core, and only for PCs with a matching tag. The bench therefore compares every core's lookup against a behavioural model on every cycle, over targeted sequences and randomized traffic that includes tag aliases.

Errors in arbitration, replacement order and retirement stay hidden until a later lookup reaches the affected PC. The directed sequences are built to make that lookup happen a few cycles after the cause.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_RESET = 2'b01;

  // One saturating step toward the observed direction.
  function automatic ctr2_t ctr_train(input ctr2_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  // Weak counter value in the direction of a fresh allocation.
  function automatic ctr2_t ctr_seed(input logic taken);
    return taken ? 2'b10 : 2'b01;
  endfunction

  // True when the counter sits at the saturated end for dir.
  function automatic logic ctr_pinned(input ctr2_t c, input logic dir);
    return dir ? (c == 2'b11) : (c == 2'b00);
  endfunction

endpackage

// File: rtl/bp_shared_table.sv
module bp_shared_table
  import bp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CORES*IDX_W-1:0] lk_idx,
  output logic [NUM_CORES-1:0]       lk_dir,
  input  logic [NUM_CORES*IDX_W-1:0] up_idx,
  output logic [NUM_CORES-1:0]       up_dir,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic                       wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  genvar g;
  generate
    for (g = 0; g < NUM_CORES; g++) begin : g_rd
      assign lk_dir[g] = mem[lk_idx[g*IDX_W +: IDX_W]][1];
      assign up_dir[g] = mem[up_idx[g*IDX_W +: IDX_W]][1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RESET;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_train(mem[wr_idx], wr_taken);
    end
  end

endmodule

// File: rtl/bp_update_arb.sv
module bp_update_arb #(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0] req,
  output logic [NUM_CORES-1:0] grant
);

  // Fixed priority: lowest index wins.
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bp_exc_table.sv
module bp_exc_table
  import bp_pkg::*;
#(
  parameter int TAG_W = 12,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             lk_dir,
  input  logic             up_valid,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_taken,
  input  logic             up_mispred,
  input  logic             up_sh_dir
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid;
  logic [TAG_W-1:0] tags [DEPTH];
  ctr2_t            ctrs [DEPTH];
  logic [PTR_W-1:0] ptr;

  logic             lk_found, up_found;
  logic [PTR_W-1:0] lk_sel, up_sel;
  ctr2_t            up_trained;
  logic             retire;

  always_comb begin
    lk_found = 1'b0;
    lk_sel   = '0;
    up_found = 1'b0;
    up_sel   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!lk_found && valid[i] && tags[i] == lk_tag) begin
        lk_found = 1'b1;
        lk_sel   = PTR_W'(i);
      end
      if (!up_found && valid[i] && tags[i] == up_tag) begin
        up_found = 1'b1;
        up_sel   = PTR_W'(i);
      end
    end
  end

  assign lk_hit     = lk_found;
  assign lk_dir     = lk_found & ctrs[lk_sel][1];
  assign up_trained = ctr_train(ctrs[up_sel], up_taken);
  assign retire     = up_found && (up_sh_dir == up_taken) && ctr_pinned(up_trained, up_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      ptr   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tags[i] <= '0;
        ctrs[i] <= CTR_RESET;
      end
    end else if (up_valid) begin
      if (up_found) begin
        if (retire) valid[up_sel] <= 1'b0;
        else        ctrs[up_sel]  <= up_trained;
      end else if (up_mispred) begin
        valid[ptr] <= 1'b1;
        tags[ptr]  <= up_tag;
        ctrs[ptr]  <= ctr_seed(up_taken);
        ptr        <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/shared_branch_predictor.sv
module shared_branch_predictor #(
  parameter int NUM_CORES = 4,
  parameter int PC_W      = 32,
  parameter int IDX_W     = 8,
  parameter int TAG_W     = 12,
  parameter int EXC_DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CORES*PC_W-1:0] lk_pc,
  output logic [NUM_CORES-1:0]      lk_taken,
  input  logic [NUM_CORES-1:0]      up_valid,
  input  logic [NUM_CORES*PC_W-1:0] up_pc,
  input  logic [NUM_CORES-1:0]      up_taken,
  input  logic [NUM_CORES-1:0]      up_mispred
);

  logic [NUM_CORES*IDX_W-1:0] lk_idx, up_idx;
  logic [NUM_CORES-1:0]       sh_lk_dir, sh_up_dir;
  logic [NUM_CORES-1:0]       sh_grant;
  logic [NUM_CORES-1:0]       exc_hit, exc_dir;
  logic [NUM_CORES-1:0]       unused_pc_bits;
  logic [IDX_W-1:0]           win_idx;
  logic                       win_taken;

  genvar c;
  generate
    for (c = 0; c < NUM_CORES; c++) begin : g_core
      logic [PC_W-1:0]  lpc, upc;
      logic [TAG_W-1:0] ltag, utag;

      assign lpc  = lk_pc[c*PC_W +: PC_W];
      assign upc  = up_pc[c*PC_W +: PC_W];
      assign ltag = lpc[2 +: TAG_W];
      assign utag = upc[2 +: TAG_W];
      assign lk_idx[c*IDX_W +: IDX_W] = lpc[2 +: IDX_W];
      assign up_idx[c*IDX_W +: IDX_W] = upc[2 +: IDX_W];
      assign unused_pc_bits[c] = ^{lpc[1:0], upc[1:0],
                                   lpc[PC_W-1:TAG_W+2], upc[PC_W-1:TAG_W+2]};

      bp_exc_table #(
        .TAG_W (TAG_W),
        .DEPTH (EXC_DEPTH)
      ) u_exc (
        .clk        (clk),
        .rst        (rst),
        .lk_tag     (ltag),
        .lk_hit     (exc_hit[c]),
        .lk_dir     (exc_dir[c]),
        .up_valid   (up_valid[c]),
        .up_tag     (utag),
        .up_taken   (up_taken[c]),
        .up_mispred (up_mispred[c]),
        .up_sh_dir  (sh_up_dir[c])
      );

      assign lk_taken[c] = exc_hit[c] ? exc_dir[c] : sh_lk_dir[c];
    end
  endgenerate

  bp_update_arb #(
    .NUM_CORES (NUM_CORES)
  ) u_arb (
    .req   (up_valid),
    .grant (sh_grant)
  );

  always_comb begin
    win_idx   = '0;
    win_taken = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (sh_grant[i]) begin
        win_idx   = up_idx[i*IDX_W +: IDX_W];
        win_taken = up_taken[i];
      end
    end
  end

  bp_shared_table #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W)
  ) u_shared (
    .clk      (clk),
    .rst      (rst),
    .lk_idx   (lk_idx),
    .lk_dir   (sh_lk_dir),
    .up_idx   (up_idx),
    .up_dir   (sh_up_dir),
    .wr_en    (|sh_grant),
    .wr_idx   (win_idx),
    .wr_taken (win_taken)
  );

endmodule

// File: rtl/shared_branch_predictor_chk.sv
module shared_branch_predictor_chk #(
  parameter int NUM_CORES = 4,
  parameter int PC_W      = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CORES*PC_W-1:0] lk_pc,
  input logic [NUM_CORES-1:0]      lk_taken,
  input logic [NUM_CORES-1:0]      up_valid,
  input logic [NUM_CORES-1:0]      sh_grant
);

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sh_grant));

  assert_grant_follows_request_R8: assert property (@(posedge clk) disable iff (rst)
    (sh_grant & ~up_valid) == '0);

  assert_request_served_R8: assert property (@(posedge clk) disable iff (rst)
    (|up_valid) |-> (|sh_grant));

  assert_core0_priority_R8: assert property (@(posedge clk) disable iff (rst)
    up_valid[0] |-> sh_grant[0]);

  assert_reset_not_taken_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lk_taken == '0);

  assert_lookup_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(up_valid) == '0 && $stable(lk_pc)) |-> $stable(lk_taken));

endmodule

bind shared_branch_predictor shared_branch_predictor_chk #(
  .NUM_CORES (NUM_CORES),
  .PC_W      (PC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_pc    (lk_pc),
  .lk_taken (lk_taken),
  .up_valid (up_valid),
  .sh_grant (sh_grant)
);

// File: tb/test_shared_branch_predictor.sv
`timescale 1ns/1ps
module test_shared_branch_predictor;

  localparam int NC   = 4;
  localparam int PCW  = 32;
  localparam int IDXW = 8;
  localparam int TAGW = 12;
  localparam int ED   = 8;
  localparam int SHD  = 1 << IDXW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NC*PCW-1:0] lk_pc   = '0;
  logic [NC*PCW-1:0] up_pc   = '0;
  logic [NC-1:0]     lk_taken;
  logic [NC-1:0]     up_valid   = '0;
  logic [NC-1:0]     up_taken   = '0;
  logic [NC-1:0]     up_mispred = '0;

  shared_branch_predictor #(
    .NUM_CORES (NC), .PC_W (PCW), .IDX_W (IDXW), .TAG_W (TAGW), .EXC_DEPTH (ED)
  ) i_shared_branch_predictor (
    .clk (clk), .rst (rst), .lk_pc (lk_pc), .lk_taken (lk_taken),
    .up_valid (up_valid), .up_pc (up_pc), .up_taken (up_taken), .up_mispred (up_mispred)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // Behavioural reference state
  int sh [SHD];
  int ev [NC][ED];
  int et [NC][ED];
  int ec [NC][ED];
  int ep [NC];

  // Stimulus for the next cycle
  logic [PCW-1:0] s_lk [NC];
  logic [PCW-1:0] s_up [NC];
  bit s_uv [NC];
  bit s_ut [NC];
  bit s_um [NC];

  function automatic int midx(logic [PCW-1:0] pc); return int'(pc[2 +: IDXW]); endfunction
  function automatic int mtag(logic [PCW-1:0] pc); return int'(pc[2 +: TAGW]); endfunction

  function automatic int mhit(int c, logic [PCW-1:0] pc);
    for (int i = 0; i < ED; i++)
      if (ev[c][i] != 0 && et[c][i] == mtag(pc)) return i;
    return -1;
  endfunction

  function automatic int mtrain(int v, bit t);
    if (t) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic int mpred(int c, logic [PCW-1:0] pc);
    int h;
    h = mhit(c, pc);
    if (h >= 0) return ec[c][h] / 2;
    return sh[midx(pc)] / 2;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < SHD; i++) sh[i] = 1;
    for (int c = 0; c < NC; c++) begin
      ep[c] = 0;
      for (int i = 0; i < ED; i++) begin ev[c][i] = 0; et[c][i] = 0; ec[c][i] = 1; end
    end
  endtask

  task automatic model_update();
    int shold [NC];
    for (int c = 0; c < NC; c++) shold[c] = sh[midx(s_up[c])];
    for (int c = 0; c < NC; c++) begin
      if (s_uv[c]) begin
        int h;
        h = mhit(c, s_up[c]);
        if (h >= 0) begin
          int n;
          n = mtrain(ec[c][h], s_ut[c]);
          if ((shold[c] / 2) == int'(s_ut[c]) && n == (s_ut[c] ? 3 : 0)) ev[c][h] = 0;
          else ec[c][h] = n;
        end else if (s_um[c]) begin
          ev[c][ep[c]] = 1;
          et[c][ep[c]] = mtag(s_up[c]);
          ec[c][ep[c]] = s_ut[c] ? 2 : 1;
          ep[c] = (ep[c] + 1) % ED;
        end
      end
    end
    for (int c = 0; c < NC; c++) begin
      if (s_uv[c]) begin
        sh[midx(s_up[c])] = mtrain(shold[c], s_ut[c]);
        break;
      end
    end
  endtask

  task automatic upd(int c, logic [PCW-1:0] pc, bit t, bit m);
    s_uv[c] = 1'b1; s_up[c] = pc; s_ut[c] = t; s_um[c] = m;
  endtask

  task automatic look_all(logic [PCW-1:0] pc);
    for (int c = 0; c < NC; c++) s_lk[c] = pc;
  endtask

  // One cycle: drive, compare every core against the model, then advance the model.
  task automatic step(string req);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      lk_pc[c*PCW +: PCW] = s_lk[c];
      up_pc[c*PCW +: PCW] = s_up[c];
      up_valid[c]   = s_uv[c];
      up_taken[c]   = s_ut[c];
      up_mispred[c] = s_um[c];
    end
    #1;
    for (int c = 0; c < NC; c++) begin
      int exp;
      exp = mpred(c, s_lk[c]);
      checks++;
      if (lk_taken[c] !== 1'(exp)) begin
        errors++;
        $display("FAIL %s core %0d pc %h: actual %b expected %0d", req, c, s_lk[c], lk_taken[c], exp);
      end
    end
    @(posedge clk);
    model_update();
    for (int c = 0; c < NC; c++) s_uv[c] = 1'b0;
  endtask

  function automatic logic [PCW-1:0] rpc();
    logic [PCW-1:0] p;
    p = PCW'(($urandom % 12) * 4);
    if ($urandom % 4 == 0) p = p | 32'h4000;
    return p;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [PCW-1:0] PA = 32'h100;
  localparam logic [PCW-1:0] PB = 32'h240;
  localparam logic [PCW-1:0] PC = 32'h380;
  localparam logic [PCW-1:0] PD = 32'h520;
  localparam logic [PCW-1:0] PD2 = 32'h524;
  localparam logic [PCW-1:0] PE = 32'h700;
  localparam logic [PCW-1:0] PG = 32'h660;

  initial begin
    model_reset();
    for (int c = 0; c < NC; c++) begin
      s_lk[c] = '0; s_up[c] = '0; s_uv[c] = 0; s_ut[c] = 0; s_um[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9: reset state, all not-taken
    for (int c = 0; c < NC; c++) s_lk[c] = PCW'(c * 64 + 4);
    step("R9 reset lookup");

    // R10 + R2: update in the same cycle shows the old value; R1 shared across cores
    look_all(PA); upd(0, PA, 1, 0); step("R10 same-cycle lookup");
    step("R1 shared visible to all cores");
    repeat (3) begin upd(0, PA, 1, 0); step("R2 saturate taken"); end
    upd(0, PA, 0, 0); step("R2 saturated stays");
    step("R2 after one not-taken");

    // R3 / R4: per-core override on a strongly taken branch
    upd(0, PB, 1, 0); step("R2 train B");
    upd(0, PB, 1, 0); step("R2 train B");
    upd(1, PB, 0, 1); look_all(PB); step("R3 allocate");
    step("R4 override only on core 1");
    look_all(PB | 32'h4000); step("R4 tag alias");

    // R3: no allocation without mispredict
    upd(2, PC, 0, 0); look_all(PC); step("R3 no alloc");
    upd(0, PC, 1, 0); step("R3 train C");
    upd(0, PC, 1, 0); step("R3 train C");
    step("R3 core2 follows shared");

    // R5: hit trains exception counter, no extra allocation
    look_all(PB);
    upd(1, PB, 0, 0); step("R5 hit train down");
    upd(1, PB, 1, 1); step("R5 hit train up");
    step("R5 override persists");

    // R6: retirement once shared is correct and entry saturates
    upd(0, PB, 0, 0); step("R6 shared down");
    upd(0, PB, 0, 0); step("R6 shared down");
    upd(1, PB, 0, 0); step("R6 retire");
    upd(0, PB, 1, 0); step("R6 shared up");
    upd(0, PB, 1, 0); step("R6 shared up");
    step("R6 core 1 follows shared after retire");

    // R8: arbitration, loser's shared write dropped, its private table still updated
    upd(0, PD, 1, 0); upd(3, PE, 1, 0); step("R8 two updates");
    s_lk[0] = PD; s_lk[3] = PE; step("R8 winner trained, loser dropped");
    upd(0, PD2, 0, 0); upd(2, PG, 1, 1); look_all(PG); step("R8 loser allocates");
    step("R8 private entry on core 2 only");

    // R7: round-robin replacement on core 3
    for (int i = 0; i <= ED; i++) begin
      upd(3, 32'h840 + PCW'(i * 4), 0, 1); step("R7 allocate");
    end
    for (int i = 0; i <= ED; i++) begin
      upd(0, 32'h840 + PCW'(i * 4), 1, 0); step("R7 shared up");
      upd(0, 32'h840 + PCW'(i * 4), 1, 0); step("R7 shared up");
    end
    for (int i = 0; i <= ED; i++) begin
      look_all(32'h840 + PCW'(i * 4)); step("R7 first slot evicted");
    end

    // Randomized traffic with aliases (R1 R2 R3 R4 R5 R6 R8)
    for (int k = 0; k < 800; k++) begin
      for (int c = 0; c < NC; c++) begin
        s_lk[c] = rpc();
        if ($urandom % 3 == 0) upd(c, rpc(), 1'($urandom % 2), 1'($urandom % 2));
      end
      step("R4 random traffic");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule